// File: doc/BRIEF.md
# Coded-Rate Serial Byte Transmitter

This block turns a stream of bytes into asynchronous serial frames on one output line that rests high. An upstream source offers a byte with a valid/ready handshake. The transmitter holds no storage of its own, so it lowers ready for as long as a byte is on the line. It raises ready again only once the stop bit has run its full length. Each frame carries a low start bit, then eight data bits with the least significant bit first, then a high stop bit. There is no parity bit.

The bit length is counted in system clocks. A 4-bit rate code selects one of thirteen standard baud rates. The clock period, given in nanoseconds as a parameter, turns the selected rate into a clocks-per-bit count. The block reads the rate code only at the moment the enable input goes from low to high. A code written at any other time waits for the next enable cycle.

While enable is low, the transmitter still takes every offered byte in a single cycle and throws it away. The upstream source therefore never stalls behind a stopped transmitter. A frame that was already on the line when enable fell is sent to the end.

Top module: `coded_rate_uart_tx`

## Requirements
- R1: While `rst_n` is low (synchronous reset), `s_ready` is 0 and `txd` is 1 from the first clock edge onward.
- R2: Whenever no frame is in progress, `txd` is 1 and `s_ready` is 1 (outside reset).
- R3: A frame is a start bit of 0, then `s_data` bits 0 through 7 in that order, then a stop bit of 1, with no parity. Each of the ten bits holds for exactly N clocks.
- R4: N equals round(1e9 / (CLK_PERIOD_NS × baud)). The rate codes select these baud rates: 0=1200, 1=2400, 2=4800, 3=9600, 4=19200, 5=38400, 6=57600, 7=115200, 8=230400, 9=460800, 10=921600, 11=1000000, 12=2000000.
- R5: `s_ready` is 0 from the clock after a byte is accepted until exactly 10×N clocks after acceptance, when it returns to 1. A byte held on the input is accepted on the next edge, so the following start bit comes after at least one idle-high clock.
- R6: `rate_code` is captured only on a clock edge where `enable` is 1 and was 0 at the previous edge. A code change while `enable` stays high does not change N.
- R7: A captured code of 13, 14 or 15 selects the rate of the `DEFAULT_CODE` parameter. Reset also loads `DEFAULT_CODE`.
- R8: While `enable` is 0, an offered byte is accepted in one cycle and dropped. `s_ready` is 1 again on the next clock, `txd` stays 1, and the byte is not sent later.
- R9: If `enable` falls during a frame, that frame completes with the timing and bits it started with.
- R10: A byte is accepted on an edge where `s_valid` and `s_ready` are both 1. With `enable` high, the start bit appears on `txd` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Transmit enable; its rising edge captures the rate code |
| rate_code | input | 4 | Coded baud-rate selection (0..12) |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Transmitter can take a byte |
| s_data | input | 8 | Input byte |
| txd | output | 1 | Serial output, high when idle |

## Verification
The bench sends frames built from bytes with asymmetric and alternating bit patterns such as 0xA5, 0x3C, 0x01 and 0x80. A swapped or shifted bit order would show up in these bytes. The line is sampled mid-bit, and again on each side of the first bit boundary. Together with the exact clock on which ready comes back, this pins N to the clock rather than only its average.

Rates 8 through 12 are each reached through a fresh enable edge, and the rounded clock counts differ between them. A code written while enabled and an out-of-range code each lead to a divisor the bench can tell apart from the previous one. Bursts sent while disabled are followed by a normal frame, which shows that nothing was queued. A frame cut off by a mid-frame disable must still match the full expected pattern.

// File: rtl/uctx_pkg.sv
// Shared constants and rate arithmetic for the coded-rate serial transmitter.
// Assumes the clock period is given in whole nanoseconds and is at least 1.
package uctx_pkg;

    localparam int RATE_COUNT = 13;
    localparam int FRAME_BITS = 10;

    // Baud rate selected by a rate code; codes past the table give 0.
    function automatic longint unsigned rate_baud(input int code);
        case (code)
            0:       return 64'd1200;
            1:       return 64'd2400;
            2:       return 64'd4800;
            3:       return 64'd9600;
            4:       return 64'd19200;
            5:       return 64'd38400;
            6:       return 64'd57600;
            7:       return 64'd115200;
            8:       return 64'd230400;
            9:       return 64'd460800;
            10:      return 64'd921600;
            11:      return 64'd1000000;
            default: return (code == 12) ? 64'd2000000 : 64'd0;
        endcase
    endfunction

    // Clocks per bit, rounded half up: floor((floor(2e9/(P*B)) + 1) / 2).
    function automatic longint unsigned bit_clocks(input int code, input int period_ns);
        longint unsigned denom;
        denom = rate_baud(code) * longint'(period_ns);
        if (denom == 0) return 64'd1;
        return (64'd2000000000 / denom + 64'd1) / 64'd2;
    endfunction

endpackage

// File: rtl/uctx_rate_latch.sv
// Rate selection: holds the active rate code and presents its clocks-per-bit.
// The code is sampled only on the edge where enable rises; out-of-range codes
// fall back to DEFAULT_CODE. Assumes DEFAULT_CODE is within the rate table.
module uctx_rate_latch #(
    parameter int CLK_PERIOD_NS = 20,
    parameter int DEFAULT_CODE  = 2,
    parameter int CNT_W         = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [3:0]       rate_code,
    output logic [CNT_W-1:0] bit_len
);
    import uctx_pkg::*;

    localparam logic [3:0] DEF_CODE = 4'(DEFAULT_CODE);

    logic [CNT_W-1:0] len_tbl [RATE_COUNT];
    logic [3:0]       code_q;
    logic             en_q;

    // One constant clocks-per-bit value per rate code.
    for (genvar g = 0; g < RATE_COUNT; g++) begin : g_rate
        assign len_tbl[g] = CNT_W'(bit_clocks(g, CLK_PERIOD_NS));
    end

    // Track enable and capture the code on its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            code_q <= DEF_CODE;
        end else begin
            en_q <= enable;
            if (enable && !en_q) begin
                code_q <= (int'(rate_code) < RATE_COUNT) ? rate_code : DEF_CODE;
            end
        end
    end

    // Select the table entry for the held code.
    always_comb begin
        bit_len = len_tbl[DEFAULT_CODE];
        for (int i = 0; i < RATE_COUNT; i++) begin
            if (code_q == 4'(i)) bit_len = len_tbl[i];
        end
    end

endmodule

// File: rtl/uctx_shifter.sv
// Frame serializer: loads start/data/stop into a shift register and moves it
// out one bit every span clocks. The span is frozen at load so a later rate
// change cannot disturb a frame in flight. Assumes load_len is at least 1.
module uctx_shifter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [7:0]       load_byte,
    input  logic [CNT_W-1:0] load_len,
    output logic             busy,
    output logic             txd
);
    import uctx_pkg::*;

    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] frame;
    logic [IDX_W-1:0]      bit_idx;
    logic [CNT_W-1:0]      cnt;
    logic [CNT_W-1:0]      span;

    // Load a frame, then count clocks per bit and shift on each bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame   <= '1;
            bit_idx <= '0;
            cnt     <= '0;
            span    <= '0;
            busy    <= 1'b0;
        end else if (load && !busy) begin
            frame   <= {1'b1, load_byte, 1'b0};
            span    <= load_len;
            cnt     <= '0;
            bit_idx <= '0;
            busy    <= 1'b1;
        end else if (busy) begin
            if (cnt == span - CNT_W'(1)) begin
                cnt   <= '0;
                frame <= {1'b1, frame[FRAME_BITS-1:1]};
                if (bit_idx == LAST_IDX) busy <= 1'b0;
                else                     bit_idx <= bit_idx + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // The line is the low bit of the frame register; it rests at all ones.
    assign txd = frame[0];

endmodule

// File: rtl/coded_rate_uart_tx.sv
// Coded-rate serial byte transmitter top. Takes bytes on a valid/ready input,
// sends them as 8N1 frames, drains and drops input while disabled.
// Assumes synchronous active-low reset and a clock of CLK_PERIOD_NS.
module coded_rate_uart_tx #(
    parameter int CLK_PERIOD_NS = 20,
    parameter int DEFAULT_CODE  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [3:0] rate_code,
    input  logic       s_valid,
    output logic       s_ready,
    input  logic [7:0] s_data,
    output logic       txd
);
    import uctx_pkg::*;

    localparam int CNT_W = $clog2(bit_clocks(0, CLK_PERIOD_NS) + 1);

    logic [CNT_W-1:0] bit_len;
    logic             busy;
    logic             run_q;
    logic             accept;

    // Hold ready low until reset has been released.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    assign s_ready = run_q && !busy;
    assign accept  = s_valid && s_ready;

    uctx_rate_latch #(
        .CLK_PERIOD_NS (CLK_PERIOD_NS),
        .DEFAULT_CODE  (DEFAULT_CODE),
        .CNT_W         (CNT_W)
    ) i_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .rate_code (rate_code),
        .bit_len   (bit_len)
    );

    uctx_shifter #(
        .CNT_W (CNT_W)
    ) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept && enable),
        .load_byte (s_data),
        .load_len  (bit_len),
        .busy      (busy),
        .txd       (txd)
    );

endmodule

// File: rtl/uctx_checker.sv
// Port-level checks for coded_rate_uart_tx, bound to every instance.
module uctx_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic s_valid,
    input logic s_ready,
    input logic txd
);
    // R2
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> txd);

    // R10
    start_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && enable) |=> (!txd && !s_ready));

    // R8
    drop_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && !enable) |=> (s_ready && txd));

    // R5
    ready_fall_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_ready) |-> !txd);

    // R5
    ready_rise_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_ready) && $past(rst_n)) |-> $past(txd));
endmodule

bind coded_rate_uart_tx uctx_checker i_uctx_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .txd     (txd)
);

// File: tb/test_coded_rate_uart_tx.sv
module test_coded_rate_uart_tx;
    localparam int PERIOD = 8;
    localparam int DEF    = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [3:0] rate_code = 4'd12;
    logic       s_valid = 1'b0;
    logic       s_ready;
    logic [7:0] s_data = 8'h00;
    logic       txd;

    int runs = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    coded_rate_uart_tx #(.CLK_PERIOD_NS(PERIOD), .DEFAULT_CODE(DEF)) i_coded_rate_uart_tx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rate_code(rate_code),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .txd(txd)
    );

    function automatic int exp_len(input int code);
        real baud;
        case (code)
            8:  baud = 230400.0;
            9:  baud = 460800.0;
            10: baud = 921600.0;
            11: baud = 1000000.0;
            default: baud = 2000000.0;
        endcase
        return $rtoi(1.0e9 / (PERIOD * baud) + 0.5);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        runs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    int cyc;
    task automatic advance_to(input int target);
        while (cyc < target) begin
            @(posedge clk);
            cyc++;
        end
        @(negedge clk);
    endtask

    // Send one byte and check bits, bit length and ready timing.
    task automatic run_frame(input logic [7:0] d, input int n, input string req, input bit drop_mid);
        logic [9:0] expv;
        logic [9:0] obs;
        bit rdy_low;
        expv = {1'b1, d, 1'b0};
        obs = '0;
        rdy_low = 1'b1;
        while (!s_ready) @(negedge clk);
        s_valid = 1'b1;
        s_data  = d;
        @(posedge clk);
        #1 s_valid = 1'b0;
        cyc = 0;
        advance_to(n / 2);
        obs[0] = txd;
        rdy_low &= !s_ready;
        advance_to(n - 1);
        check(txd == 1'b0, {req, " R3 start edge"}, txd, 0);
        advance_to(n);
        check(txd == d[0], {req, " R3 first data edge"}, txd, d[0]);
        for (int b = 1; b < 10; b++) begin
            advance_to(b * n + n / 2);
            obs[b] = txd;
            rdy_low &= !s_ready;
            if (drop_mid && b == 3) enable = 1'b0;
        end
        check(obs == expv, {req, " R3 R4 frame bits"}, obs, expv);
        check(rdy_low, {req, " R5 ready low in frame"}, rdy_low, 1);
        advance_to(10 * n - 1);
        check(!s_ready && txd, {req, " R5 ready low in stop"}, {s_ready, txd}, 1);
        advance_to(10 * n);
        check(s_ready && txd, {req, " R5 R2 ready back idle"}, {s_ready, txd}, 3);
    endtask

    task automatic set_rate(input logic [3:0] code);
        @(negedge clk);
        enable = 1'b0;
        rate_code = code;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(!s_ready && txd, "R1 reset state", {s_ready, txd}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(s_ready && txd, "R2 idle after reset", {s_ready, txd}, 3);
    endtask

    task automatic t_basic();
        set_rate(4'd12);
        run_frame(8'hA5, exp_len(12), "R10 basic", 1'b0);
        run_frame(8'h3C, exp_len(12), "R5 back-to-back", 1'b0);
    endtask

    task automatic t_code_while_on();
        rate_code = 4'd11;
        run_frame(8'h01, exp_len(12), "R6 code ignored", 1'b0);
    endtask

    task automatic t_rates();
        for (int c = 11; c >= 8; c--) begin
            set_rate(4'(c));
            run_frame(8'h80 ^ 8'(c), exp_len(c), "R4 rate", 1'b0);
        end
    endtask

    task automatic t_bad_code();
        set_rate(4'd15);
        run_frame(8'h96, exp_len(DEF), "R7 out-of-range code", 1'b0);
    endtask

    task automatic t_drop();
        bit line_ok;
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            s_valid = 1'b1;
            s_data  = 8'h10 + 8'(k);
            @(posedge clk);
            #1 s_valid = 1'b0;
            @(negedge clk);
            check(s_ready && txd, "R8 dropped byte accepted", {s_ready, txd}, 3);
        end
        line_ok = 1'b1;
        repeat (200) begin
            @(negedge clk);
            line_ok &= txd;
        end
        check(line_ok, "R8 line quiet while disabled", line_ok, 1);
        set_rate(4'd12);
        run_frame(8'h5A, exp_len(12), "R8 nothing queued", 1'b0);
    endtask

    task automatic t_disable_mid();
        set_rate(4'd11);
        run_frame(8'hC3, exp_len(11), "R9 disable mid-frame", 1'b1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_code_while_on();
        t_rates();
        t_bad_code();
        t_drop();
        t_disable_mid();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            runs++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end
endmodule